// File: doc/BRIEF.md
# Two-Channel Pulse Counter Unit

This block counts edges on two pulse inputs into a single signed 16-bit counter. Each channel also has a level control input, and that level can keep, reverse or suppress the direction an edge would give. The rising and falling edges of each channel are programmed separately. Every pulse and control input is first synchronised, then passed through a glitch filter that can be bypassed. The filter discards any level change that does not last longer than a programmable number of clock cycles.

The running count is compared with zero, an upper limit, a lower limit and two free thresholds. Each of these five compares has its own enable. An enabled compare that the count steps onto sets a sticky raw event bit. That bit is gated by an enable to form the interrupt status, and a one-cycle clear input clears it. When the count moves up to or past the upper limit, or down to or past the lower limit, it returns to zero one cycle later. All configuration arrives on plain input ports.

Top module: `pulse_tally_unit`

## Requirements
- R1: With `filt_en`=1, a level change on any input reaches the counting logic only after the synchronised input has differed from the filtered level for `filt_thres`+1 consecutive cycles. A pulse of `filt_thres` cycles or fewer is discarded.
- R2: With `filt_en`=0, the filter is bypassed, and a pulse of two clock cycles gives both a rising and a falling edge.
- R3: Each channel uses its 2-bit rising mode on a rising edge and its 2-bit falling mode on a falling edge. Value 1 gives +1, value 2 gives -1, and values 0 and 3 give no change.
- R4: The filtered control level picks the high-level mode (level 1) or the low-level mode (level 0). Control mode 0 keeps the edge direction, 1 reverses it, and 2 and 3 suppress the change.
- R5: Changes that both channels request in the same cycle are summed, giving a net change of +2, 0 or -2.
- R6: The count is signed two's complement. If an increasing update leaves it greater than or equal to `hi_lim`, it becomes 0 on the next cycle, and any steps in that cycle are dropped.
- R7: If a decreasing update leaves the count less than or equal to `lo_lim` (signed), it becomes 0 on the next cycle.
- R8: `cmp_en` bit 0 selects compare with zero, bit 1 with `hi_lim`, bit 2 with `lo_lim`, bit 3 with `thres0` and bit 4 with `thres1`. An enabled compare sets `irq_raw` on the same edge at which the count changes to that value. A disabled compare has no effect.
- R9: `irq_raw` stays set until a cycle with `irq_clr`=1 clears it. If a compare hit arrives in the same cycle as the clear, the hit wins.
- R10: `irq_status` is high exactly when both `irq_raw` and `irq_en` are high.
- R11: While `rst_n` is low, the count, `irq_raw` and `irq_status` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pulse_in | input | 2 | Pulse input, one bit per channel |
| ctrl_in | input | 2 | Control level input, one bit per channel |
| filt_en | input | 1 | Glitch filter enable |
| filt_thres | input | 10 | Filter width threshold in cycles |
| rise_mode | input | 4 | Rising-edge mode, bits [2c+1:2c] for channel c |
| fall_mode | input | 4 | Falling-edge mode, per channel |
| ctl_hi_mode | input | 4 | Control mode used while control is high |
| ctl_lo_mode | input | 4 | Control mode used while control is low |
| cmp_en | input | 5 | Compare enables: zero, high, low, thres0, thres1 |
| hi_lim | input | 16 | Upper limit (signed) |
| lo_lim | input | 16 | Lower limit (signed) |
| thres0 | input | 16 | Threshold 0 |
| thres1 | input | 16 | Threshold 1 |
| irq_en | input | 1 | Event interrupt enable |
| irq_clr | input | 1 | Clear of the raw event bit |
| count | output | 16 | Current count |
| irq_raw | output | 1 | Raw event bit |
| irq_status | output | 1 | Raw event bit gated by the enable |

## Verification
A compare hit and a clear of the raw event bit can land on the same clock edge. A collision cannot be assumed to happen by chance. The bench forces one by timing `irq_clr` to the exact cycle in which a threshold step updates the count. It then expects `irq_raw` to stay set, because the hit has priority. A second collision comes from steps on both channels in one cycle, and here the bench expects the summed change.

// File: rtl/pt_pkg.sv
// Shared types and helpers for the pulse counter unit.
// Assumes edge and control modes are 2-bit codes; unused codes are neutral.
package pt_pkg;
    localparam int STEP_W   = 3;
    localparam int NCMP     = 5;
    localparam int CMP_ZERO = 0;
    localparam int CMP_HI   = 1;
    localparam int CMP_LO   = 2;
    localparam int CMP_T0   = 3;
    localparam int CMP_T1   = 4;

    typedef logic signed [STEP_W-1:0] step_t;

    // Map an edge mode code to a signed step.
    function automatic step_t edge_step(input logic [1:0] mode);
        case (mode)
            2'd1:    return 3'sd1;
            2'd2:    return -3'sd1;
            default: return 3'sd0;
        endcase
    endfunction

    // Apply a control mode to a raw step: keep, reverse or suppress.
    function automatic step_t ctl_apply(input step_t s, input logic [1:0] mode);
        case (mode)
            2'd0:    return s;
            2'd1:    return -s;
            default: return 3'sd0;
        endcase
    endfunction
endpackage

// File: rtl/pt_glitch_filter.sv
// Synchroniser followed by a width filter for one input.
// A new level is accepted after it differs from the held level for
// thres+1 consecutive cycles; with filt_en low the synchroniser output is taken directly.
module pt_glitch_filter #(
    parameter int FILT_W      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din,
    input  logic              filt_en,
    input  logic [FILT_W-1:0] thres,
    output logic              dout
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   lvl_q;
    logic [FILT_W-1:0]      run_q;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    // Bring the asynchronous input into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
    end

    // Count the run of differing cycles and accept the level once it is long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
            run_q <= '0;
        end else if (!filt_en) begin
            lvl_q <= synced;
            run_q <= '0;
        end else if (synced == lvl_q) begin
            run_q <= '0;
        end else if (run_q >= thres) begin
            lvl_q <= synced;
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign dout = lvl_q;
endmodule

// File: rtl/pt_channel_step.sv
// Edge detector and direction logic for one channel.
// Assumes filtered, synchronous inputs; produces a signed step of -1, 0 or +1.
module pt_channel_step
    import pt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pulse_lvl,
    input  logic       ctrl_lvl,
    input  logic [1:0] rise_mode,
    input  logic [1:0] fall_mode,
    input  logic [1:0] hi_mode,
    input  logic [1:0] lo_mode,
    output step_t      step
);
    logic  prev_q;
    logic  rise, fall;
    step_t raw_step;

    // Remember the previous filtered level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pulse_lvl;
    end

    assign rise = pulse_lvl & ~prev_q;
    assign fall = ~pulse_lvl & prev_q;

    // Choose the edge mode, then let the control level modify it.
    always_comb begin
        if (rise)      raw_step = edge_step(rise_mode);
        else if (fall) raw_step = edge_step(fall_mode);
        else           raw_step = '0;
        step = ctl_apply(raw_step, ctrl_lvl ? hi_mode : lo_mode);
    end
endmodule

// File: rtl/pt_count_core.sv
// Shared signed counter with limit wrap and compare-hit detection.
// Assumes CNT_W > STEP_W; the steps of all channels are summed into one update.
module pt_count_core
    import pt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NCH   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH*STEP_W-1:0] steps_flat,
    input  logic [CNT_W-1:0]      hi_lim,
    input  logic [CNT_W-1:0]      lo_lim,
    input  logic [CNT_W-1:0]      thres0,
    input  logic [CNT_W-1:0]      thres1,
    input  logic [NCMP-1:0]       cmp_en,
    output logic [CNT_W-1:0]      count,
    output logic                  hit
);
    logic signed [CNT_W-1:0] cnt_q, nxt, sum;
    logic signed [CNT_W-1:0] hi_s, lo_s;
    logic                    wrap_q, wrap_d;
    logic [NCMP-1:0]         match;

    assign hi_s = $signed(hi_lim);
    assign lo_s = $signed(lo_lim);

    // Sum the channel steps with sign extension.
    always_comb begin
        sum = '0;
        for (int i = 0; i < NCH; i++) begin
            step_t s;
            s   = steps_flat[i*STEP_W +: STEP_W];
            sum = sum + {{(CNT_W-STEP_W){s[STEP_W-1]}}, s};
        end
    end

    // Next count, limit detection and compare matches.
    always_comb begin
        nxt    = wrap_q ? '0 : cnt_q + sum;
        wrap_d = !wrap_q && (((sum > 0) && (nxt >= hi_s)) ||
                             ((sum < 0) && (nxt <= lo_s)));
        match[CMP_ZERO] = (nxt == '0);
        match[CMP_HI]   = (nxt == hi_s);
        match[CMP_LO]   = (nxt == lo_s);
        match[CMP_T0]   = (nxt == $signed(thres0));
        match[CMP_T1]   = (nxt == $signed(thres1));
        hit = (nxt != cnt_q) && |(match & cmp_en);
    end

    // Hold the count and the pending wrap flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            wrap_q <= 1'b0;
        end else begin
            cnt_q  <= nxt;
            wrap_q <= wrap_d;
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/pulse_tally_unit.sv
// Two-channel pulse counter unit: filters, per-channel direction logic,
// shared counter and a single event interrupt with raw/enable/status/clear.
// Assumes all configuration inputs are static around the edges they govern.
module pulse_tally_unit
    import pt_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int CNT_W  = 16,
    parameter int FILT_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    pulse_in,
    input  logic [NCH-1:0]    ctrl_in,
    input  logic              filt_en,
    input  logic [FILT_W-1:0] filt_thres,
    input  logic [2*NCH-1:0]  rise_mode,
    input  logic [2*NCH-1:0]  fall_mode,
    input  logic [2*NCH-1:0]  ctl_hi_mode,
    input  logic [2*NCH-1:0]  ctl_lo_mode,
    input  logic [NCMP-1:0]   cmp_en,
    input  logic [CNT_W-1:0]  hi_lim,
    input  logic [CNT_W-1:0]  lo_lim,
    input  logic [CNT_W-1:0]  thres0,
    input  logic [CNT_W-1:0]  thres1,
    input  logic              irq_en,
    input  logic              irq_clr,
    output logic [CNT_W-1:0]  count,
    output logic              irq_raw,
    output logic              irq_status
);
    logic [NCH-1:0]        pulse_f, ctrl_f;
    logic [NCH*STEP_W-1:0] steps_flat;
    logic                  hit;
    logic                  raw_q;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        step_t ch_step;

        pt_glitch_filter #(.FILT_W(FILT_W)) u_pf (
            .clk(clk), .rst_n(rst_n), .din(pulse_in[c]),
            .filt_en(filt_en), .thres(filt_thres), .dout(pulse_f[c])
        );
        pt_glitch_filter #(.FILT_W(FILT_W)) u_cf (
            .clk(clk), .rst_n(rst_n), .din(ctrl_in[c]),
            .filt_en(filt_en), .thres(filt_thres), .dout(ctrl_f[c])
        );
        pt_channel_step u_step (
            .clk(clk), .rst_n(rst_n),
            .pulse_lvl(pulse_f[c]), .ctrl_lvl(ctrl_f[c]),
            .rise_mode(rise_mode[2*c +: 2]), .fall_mode(fall_mode[2*c +: 2]),
            .hi_mode(ctl_hi_mode[2*c +: 2]), .lo_mode(ctl_lo_mode[2*c +: 2]),
            .step(ch_step)
        );
        assign steps_flat[c*STEP_W +: STEP_W] = ch_step;
    end

    pt_count_core #(.CNT_W(CNT_W), .NCH(NCH)) u_core (
        .clk(clk), .rst_n(rst_n), .steps_flat(steps_flat),
        .hi_lim(hi_lim), .lo_lim(lo_lim), .thres0(thres0), .thres1(thres1),
        .cmp_en(cmp_en), .count(count), .hit(hit)
    );

    // Sticky raw event bit; a new hit takes priority over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= 1'b0;
        else        raw_q <= (raw_q & ~irq_clr) | hit;
    end

    assign irq_raw    = raw_q;
    assign irq_status = raw_q & irq_en;
endmodule

// File: rtl/pt_checker.sv
// Property checker for pulse_tally_unit, attached by bind.
// Assumes synchronous active-low reset; observes top-level ports only.
module pt_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_clr,
    input logic [CNT_W-1:0] count,
    input logic             irq_raw
);
    logic signed [CNT_W:0] delta;
    logic [CNT_W-1:0]      count_prev;

    // Track the previous count for the step-size check.
    always_ff @(posedge clk) begin
        if (!rst_n) count_prev <= '0;
        else        count_prev <= count;
    end

    assign delta = $signed({count[CNT_W-1], count}) - $signed({count_prev[CNT_W-1], count_prev});

    // R5: a nonzero count never moves by more than two per cycle
    p_step_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (count != '0) |-> (delta <= 2 && delta >= -2));

    // R8: the raw bit only rises on a cycle where the count changed
    p_raw_on_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_raw) |-> (count != $past(count)));

    // R9: the raw bit holds while no clear is applied
    p_raw_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_raw && !irq_clr) |=> irq_raw);

    // R9: the raw bit only falls after a clear
    p_raw_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_raw) |-> $past(irq_clr));
endmodule

bind pulse_tally_unit pt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_clr(irq_clr), .count(count), .irq_raw(irq_raw)
);

// File: tb/pulse_tally_unit_tb.sv
module pulse_tally_unit_tb_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [1:0]  pulse_in = 0, ctrl_in = 0;
    logic        filt_en = 0;
    logic [9:0]  filt_thres = 0;
    logic [3:0]  rise_mode = 0, fall_mode = 0, ctl_hi_mode = 0, ctl_lo_mode = 0;
    logic [4:0]  cmp_en = 0;
    logic [15:0] hi_lim = 16'sd30000, lo_lim = -16'sd30000, thres0 = 0, thres1 = 0;
    logic        irq_en = 0, irq_clr = 0;
    logic [15:0] count;
    logic        irq_raw, irq_status;

    int checks = 0, fails = 0;
    int ref_cnt = 0;
    bit exp_raw = 0;
    logic [1:0] plv = 0, clv = 0;
    logic [1:0] rm[2], fm[2], hm[2], lm[2];

    always #2 clk = ~clk;

    pulse_tally_unit dut_i (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .ctrl_in(ctrl_in),
        .filt_en(filt_en), .filt_thres(filt_thres), .rise_mode(rise_mode),
        .fall_mode(fall_mode), .ctl_hi_mode(ctl_hi_mode), .ctl_lo_mode(ctl_lo_mode),
        .cmp_en(cmp_en), .hi_lim(hi_lim), .lo_lim(lo_lim), .thres0(thres0),
        .thres1(thres1), .irq_en(irq_en), .irq_clr(irq_clr), .count(count),
        .irq_raw(irq_raw), .irq_status(irq_status)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_step(bit rise, logic [1:0] r, logic [1:0] f,
                                    logic [1:0] h, logic [1:0] l, bit ctl);
        int e;
        logic [1:0] m, c;
        m = rise ? r : f;
        e = (m == 2'd1) ? 1 : (m == 2'd2) ? -1 : 0;
        c = ctl ? h : l;
        return (c == 2'd0) ? e : (c == 2'd1) ? -e : 0;
    endfunction

    function automatic bit cmp_hit(int v);
        return (cmp_en[0] && v == 0) || (cmp_en[1] && v == int'($signed(hi_lim))) ||
               (cmp_en[2] && v == int'($signed(lo_lim))) ||
               (cmp_en[3] && v == int'($signed(thres0))) ||
               (cmp_en[4] && v == int'($signed(thres1)));
    endfunction

    function automatic void model_apply(int tot);
        int mid;
        mid = ref_cnt + tot;
        if (mid != ref_cnt && cmp_hit(mid)) exp_raw = 1;
        ref_cnt = mid;
        if ((tot > 0 && mid >= int'($signed(hi_lim))) ||
            (tot < 0 && mid <= int'($signed(lo_lim)))) begin
            if (mid != 0 && cmp_hit(0)) exp_raw = 1;
            ref_cnt = 0;
        end
    endfunction

    task automatic drive_cfg();
        rise_mode   = {rm[1], rm[0]};
        fall_mode   = {fm[1], fm[0]};
        ctl_hi_mode = {hm[1], hm[0]};
        ctl_lo_mode = {lm[1], lm[0]};
    endtask

    task automatic set_ctrl(input logic [1:0] v);
        clv = v; ctrl_in = v; tick(6);
    endtask

    task automatic edges(input logic [1:0] mask, input int settle);
        int tot = 0;
        drive_cfg();
        for (int ch = 0; ch < 2; ch++) begin
            if (mask[ch]) begin
                tot += exp_step(!plv[ch], rm[ch], fm[ch], hm[ch], lm[ch], clv[ch]);
                plv[ch] = !plv[ch];
            end
        end
        pulse_in = plv;
        tick(settle);
        model_apply(tot);
    endtask

    task automatic chk_cnt(input string req);
        chk(req, int'($signed(count)), ref_cnt);
    endtask

    task automatic set_ch(input int ch, input logic [1:0] r, input logic [1:0] f,
                          input logic [1:0] h, input logic [1:0] l);
        rm[ch] = r; fm[ch] = f; hm[ch] = h; lm[ch] = l;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int c = 0; c < 2; c++) set_ch(c, 0, 0, 0, 0);
        tick(4);
        // R11: reset state
        chk("R11 count", int'(count), 0);
        chk("R11 raw", int'(irq_raw), 0);
        chk("R11 status", int'(irq_status), 0);
        rst_n = 1; tick(3);

        // R3: edge mode codes
        set_ch(0, 2'd1, 2'd2, 0, 0);
        edges(2'b01, 10); chk_cnt("R3 rise inc");
        edges(2'b01, 10); chk_cnt("R3 fall dec");
        set_ch(0, 2'd3, 2'd0, 0, 0);
        edges(2'b01, 10); chk_cnt("R3 code3 none");
        edges(2'b01, 10); chk_cnt("R3 code0 none");
        set_ch(0, 2'd1, 2'd1, 0, 0);
        edges(2'b01, 10); edges(2'b01, 10); chk_cnt("R3 both edges inc");

        // R4: control modes
        set_ctrl(2'b01);
        set_ch(0, 2'd1, 2'd1, 2'd1, 2'd0);
        edges(2'b01, 10); chk_cnt("R4 reverse");
        set_ch(0, 2'd1, 2'd1, 2'd2, 2'd0);
        edges(2'b01, 10); chk_cnt("R4 hold");
        set_ctrl(2'b00);
        edges(2'b01, 10); chk_cnt("R4 low keep");

        // R5: both channels in one cycle
        set_ch(0, 2'd1, 2'd1, 0, 0); set_ch(1, 2'd1, 2'd1, 0, 0);
        edges(2'b11, 10); chk_cnt("R5 plus two");
        set_ch(1, 2'd2, 2'd2, 0, 0);
        edges(2'b11, 10); chk_cnt("R5 net zero");
        set_ch(0, 2'd2, 2'd2, 0, 0);
        edges(2'b11, 10); chk_cnt("R5 minus two");

        // R1: filter rejects narrow, accepts wide
        filt_en = 1; filt_thres = 10'd5;
        set_ch(0, 2'd1, 2'd0, 0, 0); drive_cfg();
        pulse_in[0] = 1; tick(4); pulse_in[0] = 0; tick(20);
        chk_cnt("R1 narrow rejected");
        edges(2'b01, 14); chk_cnt("R1 wide accepted");
        edges(2'b01, 14); chk_cnt("R1 wide fall");
        // R2: bypass passes a two-cycle pulse
        filt_en = 0; tick(4);
        pulse_in[0] = 1; tick(2); pulse_in[0] = 0; tick(10);
        model_apply(1);
        chk_cnt("R2 short pulse counted");

        // Random phase across R3/R4/R5
        for (int i = 0; i < 300; i++) begin
            logic [1:0] mask;
            for (int c = 0; c < 2; c++)
                set_ch(c, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                          2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)));
            set_ctrl(2'($urandom_range(0, 3)));
            mask = 2'($urandom_range(1, 3));
            edges(mask, 10);
            chk_cnt("R3/R4/R5 random");
        end
        chk("R8 disabled compares", int'(irq_raw), 0);

        // R6: upper limit wrap
        set_ctrl(2'b00);
        set_ch(0, 2'd1, 2'd1, 0, 0);
        hi_lim = 16'(ref_cnt + 3); lo_lim = -16'sd30000;
        edges(2'b01, 10); edges(2'b01, 10); chk_cnt("R6 below limit");
        edges(2'b01, 10); chk_cnt("R6 wrap to zero");
        // R7: lower limit wrap
        hi_lim = 16'sd30000; lo_lim = -16'sd3;
        set_ch(0, 2'd2, 2'd2, 0, 0);
        edges(2'b01, 10); edges(2'b01, 10); chk_cnt("R7 negative count");
        edges(2'b01, 10); chk_cnt("R7 wrap to zero");

        // R8/R10: threshold hit
        cmp_en = 5'b01000; thres0 = 16'd2; thres1 = 16'd3;
        set_ch(0, 2'd1, 2'd1, 0, 0);
        edges(2'b01, 10); chk("R8 before hit", int'(irq_raw), int'(exp_raw));
        edges(2'b01, 10); chk("R8 thres0 hit", int'(irq_raw), 1);
        chk("R10 status masked", int'(irq_status), 0);
        irq_en = 1; tick(1);
        chk("R10 status set", int'(irq_status), 1);
        // R9: clear
        irq_clr = 1; tick(1); irq_clr = 0; exp_raw = 0; tick(1);
        chk("R9 cleared", int'(irq_raw), 0);
        chk("R10 status cleared", int'(irq_status), 0);
        edges(2'b01, 10); chk("R8 disabled thres1", int'(irq_raw), 0);
        // R9: clear and hit in the same cycle, hit wins
        thres0 = 16'(ref_cnt + 1);
        plv[0] = !plv[0]; pulse_in = plv;
        tick(3); irq_clr = 1; tick(1); irq_clr = 0; tick(4);
        model_apply(1);
        chk_cnt("R9 count stepped");
        chk("R9 hit beats clear", int'(irq_raw), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule